// File: doc/BRIEF.md
# Codec Power and Mode Sequencer

This block decides when a voice/audio codec is powered and which parts of it run. Software writes a small set of control fields through a simple write port. A power-up bit sits in the highest-address control register, so a burst that walks the addresses upward can set every field and switch the device on with its final write. The selected mode then enables only the subsystems it needs: the voice transmit and receive paths, or the stereo audio DAC path. A separate field picks which output drivers run. The block also reports the channel filter type for the transmit and receive filters, chosen from the frame rate bit and a receive filter select bit.

The block runs on a free-running reference clock. The master clock and the frame sync arrive asynchronously. Each passes through a two-flop synchronizer before edge detection. A saturating counter measures how long the master clock has gone without an edge. When the counter reaches a programmable timeout, the block forces the codec down without touching the software power bit. It powers the codec again as soon as edges return.

In voice mode, the serial voice data output stays in high impedance after every transition into the powered state, including recovery from clock loss. It is driven only from the second frame sync rising edge onward.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset, `pwr_on`, every subsystem enable and `dout_oe` are 0, and every stored field is 0.
- R2: Bit 0 of a write to address NUM_REGS-1 is the power-up bit. When it is 1 and the master clock is present, `pwr_on` rises. Writing 0 drops `pwr_on`. Fields written while powered down are kept and take effect at power up. Writes to addresses of NUM_REGS or above change nothing.
- R3: If the master clock has no edge for TIMEOUT reference cycles, `clk_lost` becomes 1 and `pwr_on` goes to 0 while the power-up bit keeps its value. When edges resume, `clk_lost` clears and `pwr_on` returns if the bit is still 1.
- R4: Address 0, bit 0 selects the mode: 0 is voice, 1 is audio. When powered, voice mode sets `tx_en` and `rx_en`, and audio mode sets `dac_en`. When unpowered, all three are 0.
- R5: Address 7, bits [1:0] select the output drivers: 00 turns all drivers off, 01 enables `spk_en` only, 10 enables `hpl_en` only, and 11 enables `hpl_en` and `hpr_en`. Every driver enable is 0 when unpowered.
- R6: Address 0, bit 1 is the frame rate: 0 is 8 kHz, 1 is 16 kHz. `tx_bandpass` is 1 at 8 kHz and 0 at 16 kHz.
- R7: Address 5, bit 0 is the receive filter select. At 8 kHz, `rx_bandpass` equals this bit. At 16 kHz, `rx_bandpass` is 0.
- R8: In voice mode, `dout_oe` stays 0 after power up until the second frame sync rising edge and is 1 from then on. In audio mode, `dout_oe` stays 0.
- R9: The frame sync count restarts at every entry into the powered state, including recovery from clock loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk | input | 1 | Asynchronous master clock being monitored |
| fsync | input | 1 | Asynchronous frame sync |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Control register address |
| wr_data | input | 2 | Field bits of the write |
| pwr_on | output | 1 | Codec powered state |
| clk_lost | output | 1 | Master clock absent |
| tx_en | output | 1 | Voice transmit path enable |
| rx_en | output | 1 | Voice receive path enable |
| dac_en | output | 1 | Stereo audio DAC enable |
| spk_en | output | 1 | Differential loudspeaker driver enable |
| hpl_en | output | 1 | Left headphone driver enable |
| hpr_en | output | 1 | Right headphone driver enable |
| dout_oe | output | 1 | Serial voice data output drive enable (0 = high impedance) |
| tx_bandpass | output | 1 | Transmit filter is band-pass (0 = low-pass) |
| rx_bandpass | output | 1 | Receive filter is band-pass (0 = low-pass) |

## Verification
The bench builds the block with TIMEOUT set to 16 and keeps the 19-register address space. The short timeout lets it reach clock-loss entry and recovery in a few dozen cycles. It sweeps all 32 combinations of mode, frame rate, receive filter select and driver field, with each combination written first while unpowered and then checked after power up. It counts frame sync pulses across fresh power-ups, across loss recovery and in audio mode, and it probes addresses above the top register.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [1:0] {
        DRV_OFF     = 2'b00,
        DRV_SPK     = 2'b01,
        DRV_HPL     = 2'b10,
        DRV_HP_BOTH = 2'b11
    } drv_sel_e;

    typedef struct packed {
        logic     audio;
        logic     rate16;
        logic     rx_bp_sel;
        drv_sel_e drv;
        logic     pu;
    } cfg_t;

    localparam int unsigned MODE_ADDR = 0;
    localparam int unsigned RXF_ADDR  = 5;
    localparam int unsigned DRV_ADDR  = 7;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/cps_clk_mon.sv
module cps_clk_mon #(
    parameter int unsigned TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_sync,
    output logic lost
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    edge_seen;

    always_comb begin
        st_d      = st_q;
        edge_seen = mclk_sync ^ st_q.prev;
        st_d.prev = mclk_sync;
        if (edge_seen)             st_d.cnt = '0;
        else if (st_q.cnt != LIMIT) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost = (st_q.cnt == LIMIT);
endmodule

// File: rtl/cps_regs.sv
module cps_regs
    import cps_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned PWR_ADDR = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(MODE_ADDR)) begin
                cfg_d.audio  = wr_data[0];
                cfg_d.rate16 = wr_data[1];
            end
            if (wr_addr == ADDR_W'(RXF_ADDR)) cfg_d.rx_bp_sel = wr_data[0];
            if (wr_addr == ADDR_W'(DRV_ADDR)) cfg_d.drv       = drv_sel_e'(wr_data);
            if (wr_addr == ADDR_W'(PWR_ADDR)) cfg_d.pu        = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/cps_fs_gate.sv
module cps_fs_gate #(
    parameter int unsigned FS_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic powered,
    input  logic voice,
    input  logic fs_sync,
    output logic oe
);
    localparam int unsigned FC_W = $clog2(FS_HOLD + 1);
    localparam logic [FC_W-1:0] HOLD = FC_W'(FS_HOLD);

    typedef struct packed {
        logic            prev;
        logic [FC_W-1:0] cnt;
    } fs_st_t;

    fs_st_t st_d, st_q;
    logic   fs_rise;

    always_comb begin
        st_d      = st_q;
        fs_rise   = fs_sync & ~st_q.prev;
        st_d.prev = fs_sync;
        if (!powered)                        st_d.cnt = '0;
        else if (fs_rise && st_q.cnt != HOLD) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe = powered & voice & (st_q.cnt == HOLD);
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
    import cps_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned NUM_REGS = 19,
    parameter int unsigned TIMEOUT  = 64,
    parameter int unsigned FS_HOLD  = 2
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              mclk,
    input  logic              fsync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_data,
    output logic              pwr_on,
    output logic              clk_lost,
    output logic              tx_en,
    output logic              rx_en,
    output logic              dac_en,
    output logic              spk_en,
    output logic              hpl_en,
    output logic              hpr_en,
    output logic              dout_oe,
    output logic              tx_bandpass,
    output logic              rx_bandpass
);
    localparam int unsigned PWR_ADDR = NUM_REGS - 1;

    typedef struct packed {
        logic pwr;
    } top_st_t;

    logic [1:0] async_in, sync_out;
    logic       lost;
    cfg_t       cfg;
    top_st_t    st_d, st_q;

    assign async_in = {fsync, mclk};

    cps_sync #(.W(2)) i_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in (async_in),
        .sync_out (sync_out)
    );

    cps_clk_mon #(.TIMEOUT(TIMEOUT)) i_clk_mon (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .mclk_sync (sync_out[0]),
        .lost      (lost)
    );

    cps_regs #(.ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR)) i_regs (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pwr = cfg.pu & ~lost;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cps_fs_gate #(.FS_HOLD(FS_HOLD)) i_fs_gate (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .powered (st_q.pwr),
        .voice   (~cfg.audio),
        .fs_sync (sync_out[1]),
        .oe      (dout_oe)
    );

    assign pwr_on      = st_q.pwr;
    assign clk_lost    = lost;
    assign tx_en       = st_q.pwr & ~cfg.audio;
    assign rx_en       = st_q.pwr & ~cfg.audio;
    assign dac_en      = st_q.pwr &  cfg.audio;
    assign spk_en      = st_q.pwr & (cfg.drv == DRV_SPK);
    assign hpl_en      = st_q.pwr & (cfg.drv == DRV_HPL || cfg.drv == DRV_HP_BOTH);
    assign hpr_en      = st_q.pwr & (cfg.drv == DRV_HP_BOTH);
    assign tx_bandpass = ~cfg.rate16;
    assign rx_bandpass = ~cfg.rate16 & cfg.rx_bp_sel;
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk (
    input logic ref_clk,
    input logic rst_n,
    input logic pwr_on,
    input logic clk_lost,
    input logic tx_en,
    input logic rx_en,
    input logic dac_en,
    input logic spk_en,
    input logic hpl_en,
    input logic hpr_en,
    input logic dout_oe,
    input logic tx_bandpass,
    input logic rx_bandpass
);
    AST_DOWN_ALL_OFF: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pwr_on |-> !(tx_en || rx_en || dac_en || spk_en || hpl_en || hpr_en || dout_oe)); // R2
    AST_LOSS_POWERS_DOWN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        clk_lost |=> !pwr_on); // R3
    AST_MODE_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(dac_en && (tx_en || rx_en))); // R4
    AST_SPK_ALONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        spk_en |-> !hpl_en && !hpr_en); // R5
    AST_HPR_NEEDS_HPL: assert property (@(posedge ref_clk) disable iff (!rst_n)
        hpr_en |-> hpl_en); // R5
    AST_RX_LOWPASS_16K: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !tx_bandpass |-> !rx_bandpass); // R7
    AST_OE_VOICE_ONLY: assert property (@(posedge ref_clk) disable iff (!rst_n)
        dout_oe |-> tx_en); // R8
    AST_OE_HIZ_AT_POWERUP: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(pwr_on) |-> !dout_oe); // R9
endmodule

bind codec_pwr_seq codec_pwr_seq_chk i_chk (.*);

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned NREG    = 19;
    localparam int unsigned TMO     = 16;

    logic              ref_clk = 1'b0;
    logic              rst_n   = 1'b0;
    logic              mclk    = 1'b0;
    logic              mclk_run = 1'b1;
    logic              fsync   = 1'b0;
    logic              wr_en   = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [1:0]        wr_data = '0;
    logic pwr_on, clk_lost, tx_en, rx_en, dac_en, spk_en, hpl_en, hpr_en;
    logic dout_oe, tx_bandpass, rx_bandpass;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    codec_pwr_seq #(.ADDR_W(ADDR_W), .NUM_REGS(NREG), .TIMEOUT(TMO), .FS_HOLD(2)) i_codec_pwr_seq (
        .ref_clk(ref_clk), .rst_n(rst_n), .mclk(mclk), .fsync(fsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwr_on(pwr_on), .clk_lost(clk_lost), .tx_en(tx_en), .rx_en(rx_en),
        .dac_en(dac_en), .spk_en(spk_en), .hpl_en(hpl_en), .hpr_en(hpr_en),
        .dout_oe(dout_oe), .tx_bandpass(tx_bandpass), .rx_bandpass(rx_bandpass)
    );

    always #5 ref_clk = ~ref_clk;
    always begin
        #7;
        if (mclk_run) mclk = ~mclk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge ref_clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = 2'(data);
        @(negedge ref_clk);
        wr_en   = 1'b0;
    endtask

    task automatic fs_pulse();
        @(negedge ref_clk);
        fsync = 1'b1;
        wait_cyc(3);
        fsync = 1'b0;
        wait_cyc(5);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 outputs", {pwr_on, tx_en, rx_en, dac_en, spk_en, hpl_en, hpr_en, dout_oe}, 0);
        chk("R1 filters", {tx_bandpass, rx_bandpass}, 2'b10);
        wait_cyc(4);

        // R2/R4/R5/R6/R7 sweep: configure while down, then power up
        for (int c = 0; c < 32; c++) begin
            int audio = c & 1;
            int rate  = (c >> 1) & 1;
            int rxs   = (c >> 2) & 1;
            int drv   = (c >> 3) & 3;
            wr(NREG - 1, 0);
            wr(0, (rate << 1) | audio);
            wr(5, rxs);
            wr(7, drv);
            wait_cyc(2);
            chk("R2 down enables", {pwr_on, tx_en, rx_en, dac_en, spk_en, hpl_en, hpr_en}, 0);
            chk("R6 tx filter", tx_bandpass, 1 - rate);
            chk("R7 rx filter", rx_bandpass, (1 - rate) & rxs);
            wr(NREG - 1, 1);
            wait_cyc(2);
            chk("R2 power up", pwr_on, 1);
            chk("R4 mode enables", {tx_en, rx_en, dac_en}, audio ? 3'b001 : 3'b110);
            chk("R5 drivers", {spk_en, hpl_en, hpr_en},
                (drv == 1 ? 4 : 0) | ((drv >> 1) ? 2 : 0) | (drv == 3 ? 1 : 0));
            chk("R8 hiz before fsync", dout_oe, 0);
        end

        // R2 ignored addresses while down
        wr(NREG - 1, 0);
        wr(NREG, 1);
        wr(31, 3);
        wait_cyc(3);
        chk("R2 high address ignored", pwr_on, 0);

        // R8 voice mode frame sync gating
        wr(0, 0);
        wr(7, 0);
        wr(NREG - 1, 1);
        wait_cyc(3);
        chk("R8 oe after power up", dout_oe, 0);
        fs_pulse();
        chk("R8 oe after first fsync", dout_oe, 0);
        fs_pulse();
        chk("R8 oe after second fsync", dout_oe, 1);
        fs_pulse();
        chk("R8 oe after third fsync", dout_oe, 1);

        // R9 restart on software power cycle
        wr(NREG - 1, 0);
        wr(NREG - 1, 1);
        wait_cyc(2);
        chk("R9 oe after repower", dout_oe, 0);
        fs_pulse();
        chk("R9 oe first fsync after repower", dout_oe, 0);
        fs_pulse();
        chk("R9 oe second fsync after repower", dout_oe, 1);

        // R3 clock loss and recovery
        mclk_run = 1'b0;
        wait_cyc(TMO + 10);
        chk("R3 clk_lost set", clk_lost, 1);
        chk("R3 forced down", {pwr_on, tx_en, dout_oe}, 0);
        mclk_run = 1'b1;
        wait_cyc(8);
        chk("R3 clk_lost clear", clk_lost, 0);
        chk("R3 power restored", pwr_on, 1);
        chk("R9 oe after recovery", dout_oe, 0);
        fs_pulse();
        chk("R9 oe first fsync after recovery", dout_oe, 0);
        fs_pulse();
        chk("R9 oe second fsync after recovery", dout_oe, 1);

        // R3 recovery with bit cleared stays down
        wr(NREG - 1, 0);
        mclk_run = 1'b0;
        wait_cyc(TMO + 10);
        chk("R3 lost while down", clk_lost, 1);
        mclk_run = 1'b1;
        wait_cyc(8);
        chk("R3 no power without bit", pwr_on, 0);

        // R8 audio mode keeps output in high impedance
        wr(0, 1);
        wr(NREG - 1, 1);
        wait_cyc(2);
        fs_pulse();
        fs_pulse();
        fs_pulse();
        chk("R8 audio oe", dout_oe, 0);
        chk("R4 audio dac", dac_en, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule